// File: doc/BRIEF.md
# External Interrupt Sense and Latch Unit

This unit sits between a set of external interrupt pins and a downstream interrupt controller that only understands active-high level requests. It watches one non-maskable input and a bank of ordinary interrupt pins. It brings each of them into the local clock domain through a synchroniser. It then applies a programmable sense mode to each pin and holds the result in a status flag. Each flag is driven out directly as a level request.

Software sets the unit up through a small 32-bit register bus. The bus has a write strobe, an address, write data and combinational read data. Ordinary pins may be sensed on a low level, a falling edge, a rising edge or both edges. The non-maskable input is sensed on one edge, and a single bit picks which one. Edge-latched flags stay set until software clears them through write-one-to-clear registers. A low-level flag follows the pin: it sets while the pin is low and drops once the pin is high again, and clear writes leave it alone.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, with all pins held high, the status registers read 0, the sense registers read 0, and every request output is low.
- R2: The register map is as follows. 0x00 is NMI status, bit 0. 0x04 is NMI clear, write-one bit 0, and reads 0. 0x08 is NMI sense, bit 0. 0x10 is pin status, bits 15:0. 0x14 is pin clear, write-one bits 15:0, and reads 0. 0x18 is pin sense, 32 bits. Any other address reads 0, and a write to it changes no register.
- R3: Sense code 0 in bits [2n+1:2n] of 0x18 means low level. The status bit of pin n is 1 while the synchronised pin is low and 0 while it is high. A clear write does not change it.
- R4: Sense code 1 latches status bit n on a high-to-low transition of pin n.
- R5: Sense code 2 latches status bit n on a low-to-high transition of pin n.
- R6: Sense code 3 latches status bit n on either transition of pin n.
- R7: When pin n is in an edge mode, writing 1 to bit n of 0x14 clears status bit n. Writing 0 to a bit leaves that bit unchanged.
- R8: If an edge is detected on the same clock edge that a clear write for that flag is applied, the flag stays set.
- R9: With NMI sense 0 a falling edge sets the NMI flag, and with sense 1 a rising edge sets it. Writing 1 to bit 0 of 0x04 clears the flag.
- R10: Each request output equals its status flag at all times.
- R11: A pin change made between clock edges first shows in the status on the third rising edge after the change. Reset loads the whole synchroniser chain and the previous-value store from the pin, so leaving reset produces no edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, applied at the rising edge |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| nmi_pin | input | 1 | Non-maskable interrupt input, asynchronous |
| irq_pin | input | 16 | External interrupt inputs, asynchronous |
| nmi_req | output | 1 | Level request for the non-maskable flag |
| irq_req | output | 16 | Level requests, one per pin flag |

## Verification
The bench builds the unit with its defaults: sixteen pins, a two-flop synchroniser, an 8-bit address and a 32-bit data word. With sixteen pins the sense register is filled to bit 31, so the top field and the highest status and clear bit are all exercised. With two synchroniser stages the three-edge latency can be measured edge by edge. A random phase mixes pin toggles, clear masks and sense rewrites. This reaches the clear-versus-new-edge collision and mode changes while a flag is set, cases that directed tests hit only by timing.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'd0,
    SNS_FALL = 2'd1,
    SNS_RISE = 2'd2,
    SNS_BOTH = 2'd3
  } sense_e;

  localparam logic [7:0] A_NMI_STAT  = 8'h00;
  localparam logic [7:0] A_NMI_CLR   = 8'h04;
  localparam logic [7:0] A_NMI_SENSE = 8'h08;
  localparam logic [7:0] A_PIN_STAT  = 8'h10;
  localparam logic [7:0] A_PIN_CLR   = 8'h14;
  localparam logic [7:0] A_PIN_SENSE = 8'h18;

  // True when the mode latches on a transition rather than a level.
  function automatic logic is_edge_mode(sense_e m);
    return m != SNS_LOW;
  endfunction

  // Event seen by an edge mode given the current and previous sample.
  function automatic logic edge_hit(sense_e m, logic cur, logic prv);
    logic rise, fall;
    rise = cur & ~prv;
    fall = prv & ~cur;
    case (m)
      SNS_FALL: return fall;
      SNS_RISE: return rise;
      SNS_BOTH: return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction

  // Next value of a pin flag.
  function automatic logic flag_next(sense_e m, logic flag, logic cur,
                                     logic prv, logic clr);
    if (!is_edge_mode(m)) return ~cur;
    return edge_hit(m, cur, prv) | (flag & ~clr);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [W-1:0]             prv_q;

  // Reset loads the pin everywhere so that no transition appears on release.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= pin_i;
      prv_q <= pin_i;
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prv_q <= stage_q[STAGES-1];
    end
  end

  assign cur_o = stage_q[STAGES-1];
  assign prv_o = prv_q;
endmodule

// File: rtl/irq_cell.sv
module irq_cell
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode_i,
  input  logic   cur_i,
  input  logic   prv_i,
  input  logic   clr_i,
  output logic   flag_o
);
  logic flag_q;
  logic hit_w;
  logic edge_w;

  assign edge_w = is_edge_mode(mode_i);
  assign hit_w  = edge_hit(mode_i, cur_i, prv_i);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(mode_i, flag_q, cur_i, prv_i, clr_i);
  end

  assign flag_o = flag_q;

  p_level_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_w && !cur_i) |=> flag_q);
  p_level_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_w && cur_i) |=> !flag_q);
  p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && flag_q && !clr_i) |=> flag_q);
  p_edge_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && hit_w) |=> flag_q);
endmodule

// File: rtl/nmi_cell.sv
module nmi_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_sel_i,
  input  logic cur_i,
  input  logic prv_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic hit_w;

  assign hit_w = rise_sel_i ? (cur_i & ~prv_i) : (prv_i & ~cur_i);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= hit_w | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  p_nmi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  p_nmi_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |=> flag_q);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                nmi_pin,
  input  logic [NUM_PINS-1:0] irq_pin,
  output logic                nmi_req,
  output logic [NUM_PINS-1:0] irq_req
);
  localparam int SENSE_W = 2 * NUM_PINS;

  logic [SENSE_W-1:0]  sense_q;
  logic                nmi_rise_q;
  logic [NUM_PINS-1:0] cur_w, prv_w, flag_w, clr_w;
  logic                ncur_w, nprv_w, nflag_w, nclr_w;
  logic                hit_stat_n, hit_clr_n, hit_sense_n;
  logic                hit_stat_p, hit_clr_p, hit_sense_p;
  logic                mapped_w;

  // Address decode
  assign hit_stat_n  = bus_addr == ADDR_W'(A_NMI_STAT);
  assign hit_clr_n   = bus_addr == ADDR_W'(A_NMI_CLR);
  assign hit_sense_n = bus_addr == ADDR_W'(A_NMI_SENSE);
  assign hit_stat_p  = bus_addr == ADDR_W'(A_PIN_STAT);
  assign hit_clr_p   = bus_addr == ADDR_W'(A_PIN_CLR);
  assign hit_sense_p = bus_addr == ADDR_W'(A_PIN_SENSE);
  assign mapped_w    = hit_stat_n | hit_clr_n | hit_sense_n |
                       hit_stat_p | hit_clr_p | hit_sense_p;

  // Clear strobes, valid only for the applying edge
  assign nclr_w = bus_wr & hit_clr_n & bus_wdata[0];
  assign clr_w  = (bus_wr & hit_clr_p) ? bus_wdata[NUM_PINS-1:0] : '0;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q    <= '0;
      nmi_rise_q <= 1'b0;
    end else if (bus_wr) begin
      if (hit_sense_p) sense_q    <= bus_wdata[SENSE_W-1:0];
      if (hit_sense_n) nmi_rise_q <= bus_wdata[0];
    end
  end

  // Synchronisers
  irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(irq_pin), .cur_o(cur_w), .prv_o(prv_w));

  irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_nmi_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(nmi_pin), .cur_o(ncur_w), .prv_o(nprv_w));

  // Per-pin sense and latch
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
    irq_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .mode_i(sense_e'(sense_q[2*i +: 2])),
      .cur_i(cur_w[i]), .prv_i(prv_w[i]), .clr_i(clr_w[i]),
      .flag_o(flag_w[i]));
  end

  nmi_cell u_nmi (
    .clk(clk), .rst_n(rst_n), .rise_sel_i(nmi_rise_q),
    .cur_i(ncur_w), .prv_i(nprv_w), .clr_i(nclr_w), .flag_o(nflag_w));

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_stat_n)  bus_rdata = DATA_W'(nflag_w);
    if (hit_sense_n) bus_rdata = DATA_W'(nmi_rise_q);
    if (hit_stat_p)  bus_rdata = DATA_W'(flag_w);
    if (hit_sense_p) bus_rdata = DATA_W'(sense_q);
  end

  assign irq_req = flag_w;
  assign nmi_req = nflag_w;

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped_w |-> (bus_rdata == '0));
  p_clr_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_clr_n || hit_clr_p) |-> (bus_rdata == '0));
  p_unmapped_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !mapped_w) |=> ($stable(sense_q) && $stable(nmi_rise_q)));
endmodule

// File: tb/sim_ext_irq_sense.sv
module sim_ext_irq_sense;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          nmi_pin;
  logic [NP-1:0] irq_pin;
  logic          nmi_req;
  logic [NP-1:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ext_irq_sense u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_pin(nmi_pin),
    .irq_pin(irq_pin), .nmi_req(nmi_req), .irq_req(irq_req));

  // ---------------- reference model, written from the requirements
  logic [NP-1:0] h1, h2, hp, m_flag;
  logic          n1, n2, np_, m_nflag, m_nrise;
  logic [31:0]   m_sense;

  function automatic logic ref_pin(logic [1:0] code, logic f, logic now,
                                   logic was, logic wipe);
    logic ev;
    if (code == 2'd0) return now == 1'b0;
    ev = (code == 2'd1 && was && !now) ||
         (code == 2'd2 && !was && now) ||
         (code == 2'd3 && was != now);
    return ev ? 1'b1 : (wipe ? 1'b0 : f);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 <= irq_pin; h2 <= irq_pin; hp <= irq_pin; m_flag <= '0;
      n1 <= nmi_pin; n2 <= nmi_pin; np_ <= nmi_pin; m_nflag <= 1'b0;
      m_nrise <= 1'b0; m_sense <= '0;
    end else begin
      h1 <= irq_pin; h2 <= h1; hp <= h2;
      n1 <= nmi_pin; n2 <= n1; np_ <= n2;
      for (int i = 0; i < NP; i++)
        m_flag[i] <= ref_pin(m_sense[2*i +: 2], m_flag[i], h2[i], hp[i],
                             bus_wr && bus_addr == 8'h14 && bus_wdata[i]);
      if ((m_nrise && n2 && !np_) || (!m_nrise && np_ && !n2)) m_nflag <= 1'b1;
      else if (bus_wr && bus_addr == 8'h04 && bus_wdata[0]) m_nflag <= 1'b0;
      if (bus_wr && bus_addr == 8'h18) m_sense <= bus_wdata;
      if (bus_wr && bus_addr == 8'h08) m_nrise <= bus_wdata[0];
    end
  end

  // ---------------- helpers
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h40; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic match_model(string tag);
    logic [31:0] d;
    rd(8'h10, d);
    chk(tag, d, {16'h0, m_flag});
    chk(tag, {16'h0, irq_req}, {16'h0, m_flag});
    chk(tag, {31'h0, nmi_req}, {31'h0, m_nflag});
  endtask

  // ---------------- stimulus
  initial begin
    logic [31:0] d;
    logic [31:0] r;
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h40; bus_wdata = '0;
    nmi_pin = 1'b1; irq_pin = '1;
    settle(4);
    rst_n = 1'b1;
    settle(3);

    // R1 reset state
    rd(8'h00, d); chk("R1 nmi status", d, 0);
    rd(8'h10, d); chk("R1 pin status", d, 0);
    rd(8'h18, d); chk("R1 pin sense", d, 0);
    rd(8'h08, d); chk("R1 nmi sense", d, 0);
    chk("R1 requests", {15'h0, nmi_req, irq_req}, 0);

    // R2 register map, unmapped space
    wr(8'h18, 32'hA5C3_96F0); rd(8'h18, d); chk("R2 sense readback", d, 32'hA5C3_96F0);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); chk("R2 unmapped read", d, 0);
    wr(8'h1C, 32'h1234_5678); rd(8'h18, d); chk("R2 unmapped write ignored", d, 32'hA5C3_96F0);
    rd(8'h14, d); chk("R2 clear reads zero", d, 0);
    wr(8'h18, 32'h0);

    // R3 low level, clear has no effect
    irq_pin[3] = 1'b0; settle(4);
    rd(8'h10, d); chk("R3 low sets", d[3], 1);
    wr(8'h14, 32'hFFFF); rd(8'h10, d); chk("R3 clear ignored", d[3], 1);
    irq_pin[3] = 1'b1; settle(4);
    rd(8'h10, d); chk("R3 follows pin", d[3], 0);

    // R4 falling on pin 5, R7 clear
    wr(8'h18, 32'h1 << 10);
    irq_pin[5] = 1'b0; settle(4);
    irq_pin[5] = 1'b1; settle(4);
    rd(8'h10, d); chk("R4 falling latched", d[5], 1);
    wr(8'h14, 32'hFFDF); rd(8'h10, d); chk("R7 zero bit keeps", d[5], 1);
    wr(8'h14, 32'h0020); rd(8'h10, d); chk("R7 clear", d[5], 0);

    // R5 rising on pin 15 (top field)
    wr(8'h18, 32'h2 << 30);
    irq_pin[15] = 1'b0; settle(4);
    rd(8'h10, d); chk("R5 no event on fall", d[15], 0);
    irq_pin[15] = 1'b1; settle(4);
    rd(8'h10, d); chk("R5 rising latched", d[15], 1);
    wr(8'h14, 32'h8000);

    // R6 both edges on pin 0
    wr(8'h18, 32'h3);
    irq_pin[0] = 1'b0; settle(4);
    rd(8'h10, d); chk("R6 fall", d[0], 1);
    wr(8'h14, 32'h1); rd(8'h10, d); chk("R6 cleared", d[0], 0);
    irq_pin[0] = 1'b1; settle(4);
    rd(8'h10, d); chk("R6 rise", d[0], 1);
    wr(8'h14, 32'h1);

    // R11 latency and R8 collision, pin 9 rising
    wr(8'h18, 32'h2 << 18);
    irq_pin[9] = 1'b0; settle(4);
    @(negedge clk); irq_pin[9] = 1'b1;
    @(negedge clk); chk("R11 after one edge", irq_req[9], 0);
    @(negedge clk); chk("R11 after two edges", irq_req[9], 0);
    @(negedge clk); chk("R11 after three edges", irq_req[9], 1);
    irq_pin[9] = 1'b0; settle(4);
    @(negedge clk); irq_pin[9] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h200;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 8'h40;
    chk("R8 set wins over clear", irq_req[9], 1);
    wr(8'h14, 32'h200); chk("R8 later clear", irq_req[9], 0);
    wr(8'h18, 32'h0);

    // R9 NMI falling then rising
    nmi_pin = 1'b0; settle(4);
    rd(8'h00, d); chk("R9 nmi falling", d, 1);
    chk("R10 nmi request", nmi_req, 1);
    wr(8'h04, 32'h1); rd(8'h00, d); chk("R9 nmi clear", d, 0);
    wr(8'h08, 32'h1);
    nmi_pin = 1'b1; settle(4);
    rd(8'h00, d); chk("R9 nmi rising", d, 1);
    wr(8'h04, 32'h1);
    wr(8'h08, 32'h0);

    // R11 no false edge out of reset: NMI low through reset, falling sense
    nmi_pin = 1'b0;
    @(negedge clk); rst_n = 1'b0; settle(3); rst_n = 1'b1; settle(6);
    chk("R11 no edge from reset", nmi_req, 0);
    nmi_pin = 1'b1; settle(4);

    // Random phase against the model
    for (int it = 0; it < 3000; it++) begin
      @(negedge clk);
      checks++;
      if (irq_req !== m_flag || nmi_req !== m_nflag) begin
        errors++;
        $display("FAIL R10 random cycle %0d actual=%h/%b expected=%h/%b",
                 it, irq_req, nmi_req, m_flag, m_nflag);
      end
      irq_pin = irq_pin ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      if ($urandom_range(0, 9) == 0) nmi_pin = ~nmi_pin;
      r = $urandom_range(0, 31);
      bus_wr = 1'b0; bus_addr = 8'h40; bus_wdata = $urandom;
      if (r < 4)       begin bus_wr = 1'b1; bus_addr = 8'h14; end
      else if (r == 4) begin bus_wr = 1'b1; bus_addr = 8'h18; end
      else if (r == 5) begin bus_wr = 1'b1; bus_addr = 8'h04; end
      else if (r == 6) begin bus_wr = 1'b1; bus_addr = 8'h08; end
      else if (r == 7) begin bus_wr = 1'b1; bus_addr = 8'h2C; end
    end
    bus_wr = 1'b0;
    match_model("R4 R5 R6 R7 random end");
    rd(8'h18, d); chk("R2 random sense", d, m_sense);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule